// File: doc/BRIEF.md
# Timer Interrupt Pending and Mask Bank

This block keeps the pending flags and the enable mask for six timer interrupt sources. Sources 0 to 4 are the capture/compare channel events and source 5 is the counter overflow event. The timer logic reports each occurrence as a one-cycle pulse on `evt_i`, and that pulse latches the matching pending flag. Software uses a small register port to read the flags and to change them.

The read side offers three views: the raw pending flags, the mask, and the masked pending flags. The write side offers a direct mask write and four write-one aliases: one sets pending flags, one clears them, one sets mask bits and one clears mask bits. Software can use the pending-set alias to inject an event for diagnostics. One registered line, `irq_o`, is high whenever at least one masked flag is pending.

Register selector values, used for both `wr_addr` and `rd_addr`:

| Value | Register |
|---|---|
| 0 | mask (read and write) |
| 1 | raw pending (read) |
| 2 | masked pending (read) |
| 3 | pending set alias (write) |
| 4 | pending clear alias (write) |
| 5 | mask set alias (write) |
| 6 | mask clear alias (write) |

In every register, bit i belongs to source i: bits 0 to 4 are channels 0 to 4 and bit 5 is overflow.

Top module: `irq_bank`

## Requirements
- R1: After reset, the mask and all pending flags are 0, and `irq_o` is 0.
- R2: A 1 on `evt_i[i]` sets raw pending bit i at the next clock edge, whatever mask bit i holds.
- R3: Reading selector 2 returns the bitwise AND of the mask and the raw pending flags.
- R4: A write to selector 3 sets every raw pending bit whose data bit is 1. A write of 0 changes nothing.
- R5: A write to selector 4 clears every raw pending bit whose data bit is 1. A write of 0 changes nothing.
- R6: A write to selector 5 sets the mask bits whose data bit is 1. A write to selector 6 clears the mask bits whose data bit is 1. Data bits that are 0 leave the mask unchanged.
- R7: A write to selector 0 loads the mask from data bits 5:0. On every read, bits 31:6 of `rd_data` are 0.
- R8: When an event pulse and a pending-clear write act on the same bit in the same cycle, the bit stays set.
- R9: `irq_o` is the OR of the masked pending bits, registered once. It follows a change in the flags one clock edge after the flags change.
- R10: Reads of selectors 3, 4, 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 6 | One-cycle event pulses, one per source |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register selector |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register selector |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| irq_o | output | 1 | Combined interrupt line, registered |

## Verification
A hardware event pulse and a software pending-clear write can both act on one flag in the same cycle. The bench provokes this by driving `evt_i` in the same cycle as a write to the clear alias. The write data covers the bit that has the event and one other set bit. The expected result is that the other bit clears and the bit with the event stays set, and a raw read in the next cycle judges this.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_MASK  = 3'd0,
        SEL_RAW   = 3'd1,
        SEL_MSTAT = 3'd2,
        SEL_PSET  = 3'd3,
        SEL_PCLR  = 3'd4,
        SEL_MSET  = 3'd5,
        SEL_MCLR  = 3'd6
    } reg_sel_e;
endpackage

// File: rtl/irqb_wdec.sv
module irqb_wdec
    import irqb_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    input  logic [NSRC-1:0]  wr_bits,
    output logic             mask_ld,
    output logic [NSRC-1:0]  pend_set,
    output logic [NSRC-1:0]  pend_clr,
    output logic [NSRC-1:0]  mask_set,
    output logic [NSRC-1:0]  mask_clr
);
    always_comb begin
        mask_ld  = 1'b0;
        pend_set = '0;
        pend_clr = '0;
        mask_set = '0;
        mask_clr = '0;
        if (wr_en) begin
            case (wr_addr)
                SEL_MASK: mask_ld  = 1'b1;
                SEL_PSET: pend_set = wr_bits;
                SEL_PCLR: pend_clr = wr_bits;
                SEL_MSET: mask_set = wr_bits;
                SEL_MCLR: mask_clr = wr_bits;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/irqb_pend.sv
module irqb_pend #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] pend_set,
    input  logic [NSRC-1:0] pend_clr,
    output logic [NSRC-1:0] raw_q
);
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        // Event or set has priority over clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                raw_q[i] <= 1'b0;
            else if (evt[i] || pend_set[i])
                raw_q[i] <= 1'b1;
            else if (pend_clr[i])
                raw_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqb_mask.sv
module irqb_mask #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_ld,
    input  logic [NSRC-1:0] ld_bits,
    input  logic [NSRC-1:0] mask_set,
    input  logic [NSRC-1:0] mask_clr,
    output logic [NSRC-1:0] mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_ld)
            mask_q <= ld_bits;
        else
            mask_q <= (mask_q | mask_set) & ~mask_clr;
    end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irqb_pkg::*;
#(
    parameter int NSRC = 6,
    parameter int DW   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  evt_i,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [SEL_W-1:0] rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             irq_o
);
    localparam int PAD_W = DW - NSRC;

    logic [NSRC-1:0] pend_set, pend_clr, mask_set, mask_clr;
    logic            mask_ld;
    logic [NSRC-1:0] raw_q, mask_q, mstat;
    logic            unused_hi;

    assign unused_hi = ^wr_data[DW-1:NSRC];

    irqb_wdec #(.NSRC(NSRC)) u_wdec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_bits  (wr_data[NSRC-1:0]),
        .mask_ld  (mask_ld),
        .pend_set (pend_set),
        .pend_clr (pend_clr),
        .mask_set (mask_set),
        .mask_clr (mask_clr)
    );

    irqb_pend #(.NSRC(NSRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_i),
        .pend_set (pend_set),
        .pend_clr (pend_clr),
        .raw_q    (raw_q)
    );

    irqb_mask #(.NSRC(NSRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_ld  (mask_ld),
        .ld_bits  (wr_data[NSRC-1:0]),
        .mask_set (mask_set),
        .mask_clr (mask_clr),
        .mask_q   (mask_q)
    );

    assign mstat = mask_q & raw_q;

    always_comb begin
        case (rd_addr)
            SEL_MASK:  rd_data = {{PAD_W{1'b0}}, mask_q};
            SEL_RAW:   rd_data = {{PAD_W{1'b0}}, raw_q};
            SEL_MSTAT: rd_data = {{PAD_W{1'b0}}, mstat};
            default:   rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= |mstat;
    end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
    import irqb_pkg::*;
#(
    parameter int NSRC = 6,
    parameter int DW   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  evt_i,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_addr,
    input logic [DW-1:0]    rd_data,
    input logic             irq_o,
    input logic [NSRC-1:0]  raw_q,
    input logic [NSRC-1:0]  mask_q
);
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

    assert_rise_has_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q & ~$past(raw_q)) != '0) |->
            (($past(evt_i) != '0) || ($past(wr_en) && ($past(wr_addr) == SEL_PSET))));

    assert_fall_needs_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~raw_q & $past(raw_q)) != '0) |->
            ($past(wr_en) && ($past(wr_addr) == SEL_PCLR)));

    assert_mask_change_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q != $past(mask_q)) |->
            ($past(wr_en) && (($past(wr_addr) == SEL_MASK) ||
                              ($past(wr_addr) == SEL_MSET) ||
                              ($past(wr_addr) == SEL_MCLR))));

    assert_high_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DW-1:NSRC] == '0);

    assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i != '0) && wr_en && (wr_addr == SEL_PCLR)) |=>
            ((raw_q & $past(evt_i)) == $past(evt_i)));

    assert_irq_one_cycle_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(mask_q & raw_q)));
endmodule

bind irq_bank irq_bank_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_data (rd_data),
    .irq_o   (irq_o),
    .raw_q   (raw_q),
    .mask_q  (mask_q)
);

// File: tb/sim_irq_bank.sv
module sim_irq_bank;
    localparam int NSRC = 6;
    localparam int DW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt_i = '0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [2:0]      rd_addr = '0;
    logic [DW-1:0]   rd_data;
    logic            irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];
    event     pushed;

    always #10 clk = ~clk;

    irq_bank #(.NSRC(NSRC), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    // Monitor: compares queued expectations shortly after they are pushed
    initial begin
        forever begin
            @(pushed);
            #2;
            while (sb.size() != 0) begin
                sb_item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = it.is_irq ? {31'd0, irq_o} : rd_data;
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic push(input bit is_irq, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.is_irq = is_irq; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        -> pushed;
        #4;
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        push(1'b0, exp, tag);
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        @(negedge clk);
        push(1'b1, {31'd0, exp}, tag);
    endtask

    // Samples irq_o in the cycle right after a write, without waiting
    task automatic chk_irq_now(input bit exp, input string tag);
        push(1'b1, {31'd0, exp}, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        chk_rd(3'd0, 32'h0, "R1 mask at reset");
        chk_rd(3'd1, 32'h0, "R1 raw at reset");
        chk_irq(1'b0, "R1 irq at reset");

        pulse(6'h05);
        chk_rd(3'd1, 32'h05, "R2 event sets raw while masked off");
        chk_rd(3'd2, 32'h00, "R3 masked view with mask 0");
        chk_irq(1'b0, "R9 no irq while mask 0");

        wr(3'd0, 32'hFFFF_FFC4);
        chk_rd(3'd0, 32'h04, "R7 direct mask load, upper bits zero");
        chk_rd(3'd2, 32'h04, "R3 masked view mask&raw");
        chk_irq(1'b1, "R9 irq with masked bit pending");

        wr(3'd4, 32'h01);
        chk_rd(3'd1, 32'h04, "R5 clear alias clears bit 0");
        wr(3'd4, 32'h00);
        chk_rd(3'd1, 32'h04, "R5 clear alias write of 0 no effect");

        wr(3'd4, 32'h04);
        chk_irq_now(1'b1, "R9 irq still high one cycle after clear");
        chk_irq(1'b0, "R9 irq low after lag");

        wr(3'd3, 32'h20);
        chk_rd(3'd1, 32'h20, "R4 set alias sets overflow bit");
        chk_rd(3'd2, 32'h00, "R3 masked view overflow unmasked");
        wr(3'd3, 32'h00);
        chk_rd(3'd1, 32'h20, "R4 set alias write of 0 no effect");

        wr(3'd5, 32'h20);
        chk_rd(3'd0, 32'h24, "R6 mask set alias");
        chk_rd(3'd2, 32'h20, "R3 masked view after mask set");
        chk_irq(1'b1, "R9 irq after mask set");
        wr(3'd6, 32'h04);
        chk_rd(3'd0, 32'h20, "R6 mask clear alias");
        wr(3'd6, 32'h00);
        chk_rd(3'd0, 32'h20, "R6 mask clear alias write of 0 no effect");
        wr(3'd5, 32'h00);
        chk_rd(3'd0, 32'h20, "R6 mask set alias write of 0 no effect");

        wr(3'd4, 32'h3F);
        chk_irq(1'b0, "R9 irq low after all cleared");
        wr(3'd3, 32'h20);
        chk_irq_now(1'b0, "R9 irq still low one cycle after set");
        chk_irq(1'b1, "R9 irq high after lag");

        // Event on bit 1 and clear of bits 1 and 5 in one cycle
        @(negedge clk);
        evt_i = 6'h02; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h22;
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0; wr_data = '0;
        chk_rd(3'd1, 32'h02, "R8 event wins over clear on same bit");

        wr(3'd0, 32'h02);
        chk_rd(3'd2, 32'h02, "R3 masked view after reload");
        chk_irq(1'b1, "R9 irq from channel 1");

        chk_rd(3'd3, 32'h0, "R10 pending set alias reads 0");
        chk_rd(3'd4, 32'h0, "R10 pending clear alias reads 0");
        chk_rd(3'd5, 32'h0, "R10 mask set alias reads 0");
        chk_rd(3'd6, 32'h0, "R10 mask clear alias reads 0");
        chk_rd(3'd7, 32'h0, "R10 unused selector reads 0");

        wr(3'd0, 32'h00);
        chk_rd(3'd2, 32'h00, "R7 mask load of 0 empties masked view");
        chk_irq(1'b0, "R9 irq low after mask 0");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule